// File: doc/BRIEF.md
# Two-Level Address-Space-Tagged Translation Buffer

This block caches page table entries for virtual-to-physical translation. It has two stores. The first is a small fully associative set of slots, and software places each entry in a slot it names. The second is a larger direct-mapped array. Its row comes from the low bits of the virtual page number. Every entry carries an address space identifier (ASID) next to its virtual page number. A lookup succeeds only for the address space that installed the entry.

A two-bit command drives the block. It can stay idle, search, install into a chosen first-level slot, or install into the second level. A search returns three results: a hit flag, the stored page table entry, and a permission verdict. The verdict checks the requested execute/write/read access against the entry's flag bits, the current privilege and the supervisor-may-touch-user-pages setting. All three results are registered and change only on a search. When the paging mode is bare, a search never hits. Page walking, memory access, flushing and superpages are handled elsewhere.

Top module: `tlb2_top`

## Requirements
- R1: While reset is held and just after it, hit, perm_ok and pte_rd are 0 and no entry is valid. A search made before any install misses, however many cycles the search command is repeated.
- R2: cmd encoding is 2'b00 idle, 2'b01 search, 2'b10 install into first-level slot l1_slot, and 2'b11 install into the second level. Idle and install commands leave hit, pte_rd and perm_ok unchanged.
- R3: The results of a search appear after the rising clock edge that samples cmd=2'b01, and they hold until the next search.
- R4: An entry matches only when both its ASID equals asid_in and its virtual page number equals va_in[VA_W-1:12]. If several first-level slots match, the lowest-numbered slot supplies the entry.
- R5: A first-level match takes priority over the second level. When both stores match, pte_rd is the first-level entry.
- R6: The second level is direct-mapped, and its row is va_in[12+L2_IDX_W-1:12]. An install into a row replaces whatever entry that row held.
- R7: When xlat_mode is 0 (bare), a search reports hit=0, perm_ok=0 and pte_rd=0 whatever is stored. Any non-zero xlat_mode translates.
- R8: On a miss, pte_rd is 0 and perm_ok is 0. On a hit, pte_rd is the installed entry.
- R9: PTE bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute and bit 4 is user. acc_xwr bit 2 requests execute, bit 1 requests write and bit 0 requests read. perm_ok requires a hit, the valid bit set, and every requested bit present in the PTE.
- R10: perm_ok additionally requires one of two conditions. For a user page (bit 4 = 1) in supervisor mode (priv_sup=1), sup_user_ok must be 1. A page with bit 4 = 0 is permitted only when priv_sup=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Operation select (idle, search, install L1, install L2) |
| acc_xwr | input | 3 | Requested access: execute, write, read |
| priv_sup | input | 1 | 1 when the requester runs in supervisor mode |
| sup_user_ok | input | 1 | 1 lets supervisor mode use user pages |
| xlat_mode | input | 4 | Paging scheme, 0 = bare |
| l1_slot | input | $clog2(L1_N) | First-level slot for an L1 install |
| asid_in | input | ASID_W | Address space identifier |
| va_in | input | VA_W | Virtual address |
| pte_wr | input | PTE_W | Page table entry to install |
| hit | output | 1 | Registered search hit |
| perm_ok | output | 1 | Registered permission verdict |
| pte_rd | output | PTE_W | Registered matching page table entry |

## Verification
A corrupted tag or valid bit in either store shows at the ports on the first search that touches that entry. It appears one clock after that search command, as a wrong hit flag or a wrong pte_rd. An error in choosing between the stores shows only when both hold a match with different entries, so the stimulus installs duplicate translations on purpose. A fault in the permission logic is visible in the same cycle as the hit, through perm_ok disagreeing with the returned PTE flags. A fault in output holding is visible on the first idle or install cycle after a search.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE   = 2'b00,
      CMD_FIND   = 2'b01,
      CMD_PUT_L1 = 2'b10,
      CMD_PUT_L2 = 2'b11
   } tlb_cmd_e;

   localparam int PAGE_SHIFT = 12;
   localparam int PTE_BIT_V  = 0;
   localparam int PTE_BIT_R  = 1;
   localparam int PTE_BIT_W  = 2;
   localparam int PTE_BIT_X  = 3;
   localparam int PTE_BIT_U  = 4;
   localparam int PTE_MIN_W  = 8;
endpackage

// File: rtl/tlb2_l1_store.sv
module tlb2_l1_store #(
   parameter int N     = 8,
   parameter int TAG_W = 32,
   parameter int PTE_W = 64,
   localparam int SLOT_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [PTE_W-1:0] lk_pte
);
   logic [N-1:0]     vld_q;
   logic [TAG_W-1:0] tag_q [N];
   logic [PTE_W-1:0] pte_q [N];
   logic [N-1:0]     match;

   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            pte_q[i] <= '0;
         end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
            vld_q[i] <= 1'b1;
            tag_q[i] <= wr_tag;
            pte_q[i] <= wr_pte;
         end
      end
      assign match[i] = vld_q[i] && (tag_q[i] == lk_tag);
   end

   // lowest-numbered matching slot wins
   always_comb begin
      lk_hit = 1'b0;
      lk_pte = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) begin
            lk_hit = 1'b1;
            lk_pte = pte_q[i];
         end
      end
   end
endmodule

// File: rtl/tlb2_l2_store.sv
module tlb2_l2_store #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 28,
   parameter int PTE_W = 64,
   localparam int ROWS = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [PTE_W-1:0] lk_pte
);
   logic [ROWS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [ROWS];
   logic [PTE_W-1:0] pte_q [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         pte_q[wr_idx] <= wr_pte;
      end
   end

   assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_pte = lk_hit ? pte_q[lk_idx] : '0;
endmodule

// File: rtl/tlb2_perm.sv
module tlb2_perm
   import tlb2_pkg::*;
#(
   parameter int PTE_W = 64
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [2:0]       acc_xwr,
   input  logic             priv_sup,
   input  logic             sup_user_ok,
   output logic             ok
);
   logic [2:0] have_xwr;
   logic       flags_ok;
   logic       priv_ok;

   assign have_xwr = {pte[PTE_BIT_X], pte[PTE_BIT_W], pte[PTE_BIT_R]};
   assign flags_ok = pte[PTE_BIT_V] && ((have_xwr & acc_xwr) == acc_xwr);
   assign priv_ok  = pte[PTE_BIT_U] ? (!priv_sup || sup_user_ok) : priv_sup;
   assign ok       = flags_ok && priv_ok;
endmodule

// File: rtl/tlb2_top.sv
module tlb2_top
   import tlb2_pkg::*;
#(
   parameter int ASID_W   = 8,
   parameter int VA_W     = 36,
   parameter int PTE_W    = 64,
   parameter int L1_N     = 8,
   parameter int L2_IDX_W = 4,
   parameter bit L2_EN    = 1'b1,
   localparam int SLOT_W  = $clog2(L1_N),
   localparam int VPN_W   = VA_W - PAGE_SHIFT,
   localparam int L1_TAG_W = ASID_W + VPN_W,
   localparam int L2_TAG_W = ASID_W + VPN_W - L2_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [2:0]        acc_xwr,
   input  logic              priv_sup,
   input  logic              sup_user_ok,
   input  logic [3:0]        xlat_mode,
   input  logic [SLOT_W-1:0] l1_slot,
   input  logic [ASID_W-1:0] asid_in,
   input  logic [VA_W-1:0]   va_in,
   input  logic [PTE_W-1:0]  pte_wr,
   output logic              hit,
   output logic              perm_ok,
   output logic [PTE_W-1:0]  pte_rd
);
   if (L1_N < 2) begin : g_bad_l1
      $error("tlb2_top: L1_N must be at least 2");
   end
   if (VA_W <= PAGE_SHIFT + L2_IDX_W) begin : g_bad_va
      $error("tlb2_top: VA_W too small for page offset and L2 index");
   end
   if (PTE_W < PTE_MIN_W) begin : g_bad_pte
      $error("tlb2_top: PTE_W too small for flag bits");
   end
   if (ASID_W < 1 || L2_IDX_W < 1) begin : g_bad_w
      $error("tlb2_top: ASID_W and L2_IDX_W must be positive");
   end

   tlb_cmd_e          op;
   logic [VPN_W-1:0]  vpn;
   logic [L1_TAG_W-1:0] l1_tag;
   logic              l1_hit, l2_hit;
   logic [PTE_W-1:0]  l1_pte, l2_pte;
   logic              xlat_on;
   logic              hit_n;
   logic [PTE_W-1:0]  pte_n;
   logic              perm_c;

   assign op      = tlb_cmd_e'(cmd);
   assign vpn     = va_in[VA_W-1:PAGE_SHIFT];
   assign l1_tag  = {asid_in, vpn};
   assign xlat_on = (xlat_mode != 4'd0);

   tlb2_l1_store #(
      .N(L1_N), .TAG_W(L1_TAG_W), .PTE_W(PTE_W)
   ) u_l1 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(op == CMD_PUT_L1), .wr_slot(l1_slot),
      .wr_tag(l1_tag), .wr_pte(pte_wr),
      .lk_tag(l1_tag), .lk_hit(l1_hit), .lk_pte(l1_pte)
   );

   if (L2_EN) begin : g_l2
      logic [L2_IDX_W-1:0] idx;
      logic [L2_TAG_W-1:0] tag;
      assign idx = vpn[L2_IDX_W-1:0];
      assign tag = {asid_in, vpn[VPN_W-1:L2_IDX_W]};
      tlb2_l2_store #(
         .IDX_W(L2_IDX_W), .TAG_W(L2_TAG_W), .PTE_W(PTE_W)
      ) u_l2 (
         .clk(clk), .rst_n(rst_n),
         .wr_en(op == CMD_PUT_L2), .wr_idx(idx),
         .wr_tag(tag), .wr_pte(pte_wr),
         .lk_idx(idx), .lk_tag(tag),
         .lk_hit(l2_hit), .lk_pte(l2_pte)
      );
   end else begin : g_no_l2
      assign l2_hit = 1'b0;
      assign l2_pte = '0;
   end

   always_comb begin
      hit_n = xlat_on && (l1_hit || l2_hit);
      pte_n = '0;
      if (hit_n) pte_n = l1_hit ? l1_pte : l2_pte;
   end

   tlb2_perm #(.PTE_W(PTE_W)) u_perm (
      .pte(pte_n), .acc_xwr(acc_xwr), .priv_sup(priv_sup),
      .sup_user_ok(sup_user_ok), .ok(perm_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         perm_ok <= 1'b0;
         pte_rd  <= '0;
      end else if (op == CMD_FIND) begin
         hit     <= hit_n;
         perm_ok <= hit_n && perm_c;
         pte_rd  <= pte_n;
      end
   end
endmodule

// File: rtl/tlb2_chk.sv
module tlb2_chk #(
   parameter int PTE_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cmd,
   input logic [2:0]       acc_xwr,
   input logic             priv_sup,
   input logic [3:0]       xlat_mode,
   input logic             hit,
   input logic             perm_ok,
   input logic [PTE_W-1:0] pte_rd
);
   AST_HOLD_OFF_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 2'b01) |=> ($stable(hit) && $stable(perm_ok) && $stable(pte_rd))); // R2
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (pte_rd == '0 && !perm_ok)); // R8
   AST_BARE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && xlat_mode == 4'd0) |=> !hit); // R7
   AST_ACC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01) |=> (!perm_ok ||
         (pte_rd[0] && ((pte_rd[3:1] & $past(acc_xwr)) == $past(acc_xwr))))); // R9
   AST_SUP_PAGE_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && !priv_sup) |=> (!perm_ok || pte_rd[4])); // R10
endmodule

bind tlb2_top tlb2_chk #(.PTE_W(PTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .acc_xwr(acc_xwr),
   .priv_sup(priv_sup), .xlat_mode(xlat_mode),
   .hit(hit), .perm_ok(perm_ok), .pte_rd(pte_rd)
);

// File: tb/sim_tlb2_top.sv
module sim_tlb2_top;
   localparam int ASID_W = 8;
   localparam int VA_W   = 36;
   localparam int PTE_W  = 64;
   localparam int L1_N   = 8;
   localparam int IDX_W  = 4;
   localparam int VPN_W  = VA_W - 12;
   localparam int ROWS   = 1 << IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cmd = 2'b00;
   logic [2:0]        acc_xwr = 3'b000;
   logic              priv_sup = 1'b0;
   logic              sup_user_ok = 1'b0;
   logic [3:0]        xlat_mode = 4'd0;
   logic [2:0]        l1_slot = '0;
   logic [ASID_W-1:0] asid_in = '0;
   logic [VA_W-1:0]   va_in = '0;
   logic [PTE_W-1:0]  pte_wr = '0;
   logic              hit, perm_ok;
   logic [PTE_W-1:0]  pte_rd;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tlb2_top u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .acc_xwr(acc_xwr),
      .priv_sup(priv_sup), .sup_user_ok(sup_user_ok), .xlat_mode(xlat_mode),
      .l1_slot(l1_slot), .asid_in(asid_in), .va_in(va_in), .pte_wr(pte_wr),
      .hit(hit), .perm_ok(perm_ok), .pte_rd(pte_rd)
   );

   // bench reference state
   bit              m1_v [L1_N];
   bit [ASID_W-1:0] m1_a [L1_N];
   bit [VPN_W-1:0]  m1_p [L1_N];
   bit [PTE_W-1:0]  m1_e [L1_N];
   bit              m2_v [ROWS];
   bit [ASID_W-1:0] m2_a [ROWS];
   bit [VPN_W-1:0]  m2_p [ROWS];
   bit [PTE_W-1:0]  m2_e [ROWS];
   bit              e_hit, e_perm;
   bit [PTE_W-1:0]  e_pte;

   function automatic bit perm_of(bit [PTE_W-1:0] p, bit [2:0] a, bit s, bit su);
      if (!p[0]) return 0;
      if ((p[3:1] & a) != a) return 0;
      if (p[4]) return (!s || su);
      return s;
   endfunction

   task automatic chk(string req, string what, logic [PTE_W-1:0] act, logic [PTE_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic op(bit [1:0] c, bit [2:0] slot, bit [ASID_W-1:0] asid,
                     bit [VPN_W-1:0] vpn, bit [PTE_W-1:0] pte, bit [2:0] acc,
                     bit sup, bit su, bit [3:0] mode, string req);
      bit h = 0;
      bit [PTE_W-1:0] pe = '0;
      bit [IDX_W-1:0] row = vpn[IDX_W-1:0];
      if (c == 2'b01) begin
         if (mode != 0) begin
            for (int i = L1_N - 1; i >= 0; i--)
               if (m1_v[i] && m1_a[i] == asid && m1_p[i] == vpn) begin
                  h = 1; pe = m1_e[i];
               end
            if (!h && m2_v[row] && m2_a[row] == asid && m2_p[row] == vpn) begin
               h = 1; pe = m2_e[row];
            end
         end
         e_hit = h; e_pte = pe; e_perm = h && perm_of(pe, acc, sup, su);
      end
      cmd = c; l1_slot = slot; asid_in = asid;
      va_in = {vpn, 12'($urandom_range(0, 4095))};
      pte_wr = pte; acc_xwr = acc; priv_sup = sup; sup_user_ok = su; xlat_mode = mode;
      @(negedge clk);
      chk(req, "hit", {63'd0, hit}, {63'd0, e_hit});
      chk(req, "pte_rd", pte_rd, e_pte);
      chk(req, "perm_ok", {63'd0, perm_ok}, {63'd0, e_perm});
      if (c == 2'b10) begin
         m1_v[slot] = 1; m1_a[slot] = asid; m1_p[slot] = vpn; m1_e[slot] = pte;
      end else if (c == 2'b11) begin
         m2_v[row] = 1; m2_a[row] = asid; m2_p[row] = vpn; m2_e[row] = pte;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit [VPN_W-1:0] va_a, va_b, va_c;
      void'($urandom(32'd4242));
      e_hit = 0; e_perm = 0; e_pte = '0;
      repeat (3) @(negedge clk);
      chk("R1", "reset hit", {63'd0, hit}, 64'd0);
      chk("R1", "reset pte_rd", pte_rd, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty buffer, search held many cycles
      for (int i = 0; i < 10; i++) op(2'b01, 0, 8'h00, 24'h0, 0, 3'b111, 0, 0, 4'd9, "R1");
      va_a = 24'h012345; va_b = 24'h0ABCD5; va_c = 24'h777775; // share L2 row 5
      // R4 L1 install and hit; ASID mismatch misses
      op(2'b10, 3, 8'h11, va_a, 64'hAAAA_0000_0000_001F, 0, 0, 0, 4'd8, "R2");
      op(2'b01, 0, 8'h11, va_a, 0, 3'b011, 0, 0, 4'd8, "R4");
      op(2'b00, 0, 8'h00, 0, 0, 0, 0, 0, 4'd0, "R2");
      op(2'b01, 0, 8'h12, va_a, 0, 3'b001, 0, 0, 4'd8, "R4");
      // R4 lowest slot wins among duplicates
      op(2'b10, 1, 8'h11, va_a, 64'hBBBB_0000_0000_0013, 0, 0, 0, 4'd8, "R2");
      op(2'b01, 0, 8'h11, va_a, 0, 3'b001, 0, 0, 4'd8, "R4");
      // R6 L2 install, hit, eviction by same row
      op(2'b11, 0, 8'h22, va_b, 64'hCCCC_0000_0000_000F, 0, 1, 0, 4'd9, "R6");
      op(2'b01, 0, 8'h22, va_b, 0, 3'b100, 1, 0, 4'd9, "R6");
      op(2'b11, 0, 8'h22, va_c, 64'hDDDD_0000_0000_0003, 0, 0, 0, 4'd9, "R6");
      op(2'b01, 0, 8'h22, va_b, 0, 3'b001, 1, 0, 4'd9, "R6");
      op(2'b01, 0, 8'h22, va_c, 0, 3'b001, 1, 0, 4'd9, "R6");
      // R5 L1 beats L2
      op(2'b11, 0, 8'h11, va_a, 64'hEEEE_0000_0000_0003, 0, 0, 0, 4'd9, "R5");
      op(2'b01, 0, 8'h11, va_a, 0, 3'b001, 0, 0, 4'd9, "R5");
      // R7 bare mode
      op(2'b01, 0, 8'h11, va_a, 0, 3'b001, 0, 0, 4'd0, "R7");
      // R10 privilege
      op(2'b10, 6, 8'h33, 24'h000100, 64'h0000_0000_0000_0013, 0, 0, 0, 4'd8, "R10");
      op(2'b01, 0, 8'h33, 24'h000100, 0, 3'b001, 1, 0, 4'd8, "R10");
      op(2'b01, 0, 8'h33, 24'h000100, 0, 3'b001, 1, 1, 4'd8, "R10");
      op(2'b01, 0, 8'h33, 24'h000100, 0, 3'b001, 0, 0, 4'd8, "R10");
      op(2'b01, 0, 8'h22, va_c, 0, 3'b001, 0, 0, 4'd8, "R10");
      // R9 missing access bit, invalid PTE
      op(2'b01, 0, 8'h33, 24'h000100, 0, 3'b100, 0, 0, 4'd8, "R9");
      op(2'b10, 7, 8'h33, 24'h000200, 64'h0000_0000_0000_001E, 0, 0, 0, 4'd8, "R9");
      op(2'b01, 0, 8'h33, 24'h000200, 0, 3'b000, 0, 0, 4'd8, "R9");
      // R8 miss gives zero PTE
      op(2'b01, 0, 8'h44, 24'h000300, 0, 3'b000, 1, 0, 4'd8, "R8");
      // constrained random mix, R3 timing and hold on every op
      for (int n = 0; n < 3000; n++) begin
         bit [1:0] c = 2'($urandom_range(0, 3));
         bit [VPN_W-1:0] v = {20'($urandom_range(0, 1)), 4'($urandom_range(0, 7))};
         bit [PTE_W-1:0] p = {32'($urandom), 27'd0, 5'($urandom)};
         op(c, 3'($urandom_range(0, 7)), 8'($urandom_range(1, 2)), v, p,
            3'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 7) == 0) ? 4'd0 : 4'd9, "R3");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule